// File: doc/BRIEF.md
# Keyed Frame-Pulse Watchdog

This block guards against stalled software by counting frame-sync pulses. Software restarts it by writing a fixed key pattern into a write-only 8-bit service register. If the key does not arrive within a fixed number of frame periods, an active-low expiry output is asserted. A write of any other byte is ignored.

Time is counted in frame periods rather than system clocks. The frame input is sampled in the system clock domain, and only its rising edges advance the count. After the expiry output drops, it stays low until the key is written again. That same key write also restarts the count from zero.

Top module: `frame_watchdog`

## Requirements
- R1: A write whose data bits [4:0] equal 5'b01010 restarts the count at zero and drives `wd_n` high on the next clock edge. Bits [7:5] are ignored, so 8'h0A, 8'hEA and 8'h4A all act as the key.
- R2: A write whose bits [4:0] differ from 5'b01010 changes neither the count nor `wd_n`.
- R3: `wd_n` goes low at the clock edge that samples the TIMEOUT-th counted rising frame edge since the last restart or reset, and not before. TIMEOUT defaults to 1024.
- R4: The count advances only on a low-to-high change of the sampled `frame_in`. A level held high for many cycles counts once.
- R5: Once `wd_n` is low, it stays low under any frame activity until a key write arrives.
- R6: A key write and a counted frame edge in the same cycle leave the count at zero, so a further TIMEOUT edges are needed to expire.
- R7: After reset the count is zero and `wd_n` is high. A `frame_in` already high at reset release is not counted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service register write data |
| frame_in | input | 1 | Frame-sync pulse, sampled on clk |
| wd_n | output | 1 | Active-low watchdog expiry |

## Verification
The hardest case to reach is the exact expiry boundary, especially when a restart falls on the same cycle as a frame edge. The stimulus steps frame pulses one at a time up to TIMEOUT-1. It then drives the key and a rising edge on the same negative clock edge. After that it counts a full TIMEOUT-1 further pulses to show the output still high, and one more to show it falling. A long high frame level placed inside such a run shows that levels are not counted, because it shifts the expiry by exactly the edges it would otherwise have added.

// File: rtl/frame_watchdog.sv
module frame_watchdog #(
  parameter int TIMEOUT = 1024,
  parameter int DW      = 8,
  parameter int KW      = 5,
  parameter logic [KW-1:0] KEY = 5'b01010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_in,
  output logic          wd_n
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          frame_q;
  logic [CW-1:0] cnt;
  logic          edge_seen;
  logic          kick;

  assign edge_seen = frame_in & ~frame_q;
  assign kick      = wr_en && (wr_data[KW-1:0] == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wd_n <= 1'b1;
    end else if (kick) begin
      cnt  <= '0;
      wd_n <= 1'b1;
    end else if (edge_seen && wd_n) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) wd_n <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_watchdog_chk.sv
module frame_watchdog_chk #(
  parameter int TIMEOUT = 1024,
  parameter int DW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          frame_in,
  input logic          wd_n
);
  localparam int RW = $clog2(TIMEOUT + 1) + 1;
  logic          prev_f;
  logic [RW-1:0] seen;
  logic          good;

  assign good = wr_en && (wr_data[4:0] == 5'b01010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_f <= 1'b1;
      seen   <= '0;
    end else begin
      prev_f <= frame_in;
      if (good) seen <= '0;
      else if (frame_in && !prev_f && seen < RW'(TIMEOUT)) seen <= seen + 1'b1;
    end
  end

  AST_KEY_RESTORES: assert property (@(posedge clk) disable iff (!rst_n) good |=> wd_n); // R1
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!wd_n && !good) |=> !wd_n); // R5
  AST_RISE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_n) |-> $past(good)); // R2
  AST_EXPIRE_EXACT: assert property (@(posedge clk) disable iff (!rst_n) wd_n == (seen < RW'(TIMEOUT))); // R3
  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(wd_n) |-> $past(frame_in)); // R4
endmodule

bind frame_watchdog frame_watchdog_chk #(.TIMEOUT(TIMEOUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .frame_in(frame_in), .wd_n(wd_n)
);

// File: tb/frame_watchdog_test.sv
module frame_watchdog_test;
  localparam int TO = 1024;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, frame_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wd_n;
  int checks = 0, fails = 0;

  frame_watchdog #(.TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .frame_in(frame_in), .wd_n(wd_n)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wd_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_in = 1'b1;
      @(negedge clk) frame_in = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R7", wd_n, 1'b1);
    pulses(TO - 1);
    check("R7", wd_n, 1'b1);
    pulses(1);
    check("R3", wd_n, 1'b0);
  endtask

  task automatic t_hold_low();
    pulses(40);
    check("R5", wd_n, 1'b0);
    wr(8'h1A);
    check("R5", wd_n, 1'b0);
    wr(8'hEA);
    check("R1", wd_n, 1'b1);
  endtask

  task automatic t_boundary();
    wr(8'h0A);
    pulses(TO - 1);
    check("R3", wd_n, 1'b1);
    pulses(1);
    check("R3", wd_n, 1'b0);
    wr(8'h4A);
    check("R1", wd_n, 1'b1);
  endtask

  task automatic t_bad_writes();
    wr(8'h0A);
    pulses(1000);
    wr(8'h0B); wr(8'h00); wr(8'h1A); wr(8'hFF); wr(8'h08);
    pulses(23);
    check("R2", wd_n, 1'b1);
    pulses(1);
    check("R2", wd_n, 1'b0);
  endtask

  task automatic t_restart_mid();
    wr(8'h0A);
    pulses(1000);
    wr(8'hCA);
    pulses(TO - 1);
    check("R1", wd_n, 1'b1);
    pulses(1);
    check("R1", wd_n, 1'b0);
  endtask

  task automatic t_same_cycle();
    wr(8'h0A);
    pulses(TO - 1);
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h2A; frame_in = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; frame_in = 1'b0; end
    check("R6", wd_n, 1'b1);
    pulses(TO - 1);
    check("R6", wd_n, 1'b1);
    pulses(1);
    check("R6", wd_n, 1'b0);
  endtask

  task automatic t_level();
    wr(8'h0A);
    @(negedge clk) frame_in = 1'b1;
    repeat (60) @(negedge clk);
    frame_in = 1'b0;
    pulses(TO - 2);
    check("R4", wd_n, 1'b1);
    pulses(1);
    check("R4", wd_n, 1'b0);
  endtask

  task automatic t_reset_high();
    @(negedge clk) begin rst_n = 1'b0; frame_in = 1'b1; end
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame_in = 1'b0;
    pulses(TO - 1);
    check("R7", wd_n, 1'b1);
    pulses(1);
    check("R7", wd_n, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_low();
    t_boundary();
    t_bad_writes();
    t_restart_mid();
    t_same_cycle();
    t_level();
    t_reset_high();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule